// File: doc/BRIEF.md
# Card Column Timing Sequencer

This block reproduces the mechanical timing of a punched-card reader/punch so that a host processor sees the same timing it would see on the real machine. A start-read or start-punch command raises busy and begins a feed delay while the card travels to the sensing station. Column interrupts then follow one per column at a fixed mechanical interval. Each column's 12-bit row pattern comes from an internal 80-word card buffer, which the host loads through a simple write port. After the last column the card coasts into the next station. The block then pulses a completion flag and drops busy.

The interrupt cadence never waits for the host. If the host fails to fetch a column before the next one arrives, a sticky overrun flag records the loss. That flag is cleared by the next accepted start. All delays are clock-cycle counts computed from a clock-frequency parameter in kHz, as `cycles = CLK_KHZ * microseconds / 1000`, truncated. This allows a test to scale time down.

Top module: `card_column_sequencer`

## Requirements
- R1: After a synchronous reset, busy, col_irq, complete and overrun are 0 and col_num is 0.
- R2: A start accepted at clock edge E makes busy 1 from E onward. col_irq first rises at edge E + FEED_CYC, with col_num = 1. FEED_CYC is the 20 ms feed delay in cycles.
- R3: In read mode, column k (1..80) begins at edge E + FEED_CYC + (k-1)*READ_CYC. READ_CYC is 1.125 ms in cycles.
- R4: In punch mode, the column spacing is PUNCH_CYC (6.125 ms in cycles) instead of READ_CYC.
- R5: While a column is presented, col_data equals buffer word col_num-1. Buffer address 0 holds column 1, and a write to an address of 80 or above is dropped.
- R6: col_irq rises at each column start. It stays high until the first edge at which col_read is sampled high, or until the column ends. A col_read sampled while col_irq is low has no effect.
- R7: Column starts follow R3/R4 exactly, however early or late the host reads, and also when it never reads.
- R8: overrun becomes 1 at a column start whenever the previous column's interrupt was still pending at that edge and col_read was low. overrun stays 1 until the next accepted start, which clears it.
- R9: After column 80 ends, the block waits STOP_CYC (40 ms in cycles). Then complete is 1 for exactly one cycle with busy already 0, and afterwards both stay 0.
- R10: A start command while busy is 1 is ignored: the mode and all timing are unchanged.
- R11: If start_read and start_punch are high together on an accepted start, read mode is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_read | input | 1 | Start a read cycle (one-cycle command) |
| start_punch | input | 1 | Start a punch cycle (one-cycle command) |
| col_read | input | 1 | Host fetch strobe for the current column |
| buf_we | input | 1 | Card buffer write enable |
| buf_addr | input | 7 | Card buffer word address (0 = column 1) |
| buf_wdata | input | 12 | Row pattern to store |
| busy | output | 1 | Card cycle in progress |
| col_irq | output | 1 | Column interrupt |
| col_num | output | 7 | Current column number, 1..80 (0 before the first column) |
| col_data | output | 12 | Row pattern of the current column |
| complete | output | 1 | One-cycle operation-complete pulse |
| overrun | output | 1 | Sticky missed-column flag |

## Verification
Read cards are run with three host behaviours: a host that strobes every cycle, a host that never strobes, and a host that strobes with random sparse probability. Comparing them separates the free-running column schedule from the interrupt-hold and overrun logic. Punch cards use a low and a moderate strobe rate, so that the longer interval and missed columns both occur. Random buffer contents expose any off-by-one between column number and buffer word. Extra starts injected mid-card, and a card started with both commands high, show whether a command during busy or a simultaneous command changes the mode or the timing.

// File: rtl/card_column_sequencer.sv
module card_column_sequencer #(
  parameter int CLK_KHZ      = 50000,
  parameter int COLS         = 80,
  parameter int ROWS         = 12,
  parameter int FEED_US      = 20000,
  parameter int READ_COL_US  = 1125,
  parameter int PUNCH_COL_US = 6125,
  parameter int STOP_US      = 40000
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start_read,
  input  logic                      start_punch,
  input  logic                      col_read,
  input  logic                      buf_we,
  input  logic [$clog2(COLS)-1:0]   buf_addr,
  input  logic [ROWS-1:0]           buf_wdata,
  output logic                      busy,
  output logic                      col_irq,
  output logic [$clog2(COLS+1)-1:0] col_num,
  output logic [ROWS-1:0]           col_data,
  output logic                      complete,
  output logic                      overrun
);

  localparam int AW = $clog2(COLS);
  localparam int CLW = $clog2(COLS+1);
  localparam int FEED_CYC  = int'(64'(CLK_KHZ) * 64'(FEED_US) / 64'd1000);
  localparam int READ_CYC  = int'(64'(CLK_KHZ) * 64'(READ_COL_US) / 64'd1000);
  localparam int PUNCH_CYC = int'(64'(CLK_KHZ) * 64'(PUNCH_COL_US) / 64'd1000);
  localparam int STOP_CYC  = int'(64'(CLK_KHZ) * 64'(STOP_US) / 64'd1000);
  localparam int CW = $clog2(FEED_CYC + READ_CYC + PUNCH_CYC + STOP_CYC + 1);
  localparam logic [CW-1:0] FEED_LIM  = CW'(FEED_CYC - 1);
  localparam logic [CW-1:0] READ_LIM  = CW'(READ_CYC - 1);
  localparam logic [CW-1:0] PUNCH_LIM = CW'(PUNCH_CYC - 1);
  localparam logic [CW-1:0] STOP_LIM  = CW'(STOP_CYC - 1);
  localparam logic [CLW-1:0] LAST_COL = CLW'(COLS);

  typedef enum logic [2:0] {
    S_IDLE, S_FEED, S_CWAIT, S_CIRQ, S_STOP, S_DONE
  } st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic [CLW-1:0] col;
  logic           punch_mode;
  logic           ovr;
  logic [ROWS-1:0] mem [COLS];

  wire go      = (start_read | start_punch) & ~busy;
  wire col_end = (cnt == (punch_mode ? PUNCH_LIM : READ_LIM));
  wire [AW-1:0] rd_idx = AW'(col - CLW'(1));

  always_ff @(posedge clk) begin
    if (buf_we && int'(buf_addr) < COLS)
      mem[buf_addr] <= buf_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      cnt        <= '0;
      col        <= '0;
      punch_mode <= 1'b0;
      ovr        <= 1'b0;
    end else begin
      case (st)
        S_IDLE, S_DONE: begin
          st <= S_IDLE;
          if (go) begin
            st         <= S_FEED;
            cnt        <= '0;
            col        <= '0;
            ovr        <= 1'b0;
            punch_mode <= ~start_read;
          end
        end
        S_FEED: begin
          if (cnt == FEED_LIM) begin
            cnt <= '0;
            col <= CLW'(1);
            st  <= S_CIRQ;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_CIRQ, S_CWAIT: begin
          if (col_end) begin
            cnt <= '0;
            if (col == LAST_COL) begin
              st <= S_STOP;
            end else begin
              col <= col + 1'b1;
              st  <= S_CIRQ;
              if (st == S_CIRQ && !col_read) ovr <= 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
            if (st == S_CIRQ && col_read) st <= S_CWAIT;
          end
        end
        S_STOP: begin
          if (cnt == STOP_LIM) st <= S_DONE;
          else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy     = (st == S_FEED) || (st == S_CIRQ) || (st == S_CWAIT) || (st == S_STOP);
  assign col_irq  = (st == S_CIRQ);
  assign complete = (st == S_DONE);
  assign overrun  = ovr;
  assign col_num  = col;
  assign col_data = (col == '0) ? '0 : mem[rd_idx];

  // R9
  complete_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    complete |=> !complete);

  // R9
  complete_idle_chk: assert property (@(posedge clk) disable iff (rst)
    complete |-> !busy);

  // R6
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    col_irq && !col_read && col_num != LAST_COL |=> col_irq);

  // R6
  irq_drop_chk: assert property (@(posedge clk) disable iff (rst)
    col_irq && col_read |=> !col_irq || col_num != $past(col_num));

  // R8
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overrun && !((start_read || start_punch) && !busy) |=> overrun);

  // R10
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    busy && (start_read || start_punch) |=> busy && $stable(punch_mode));

  // R5
  col_range_chk: assert property (@(posedge clk) disable iff (rst)
    col_irq |-> col_num >= CLW'(1) && col_num <= LAST_COL);

endmodule

// File: tb/sim_card_column_sequencer.sv
module sim_card_column_sequencer;
  localparam int KHZ   = 8;
  localparam int FEED  = KHZ * 20000 / 1000;
  localparam int RDC   = KHZ * 1125 / 1000;
  localparam int PNC   = KHZ * 6125 / 1000;
  localparam int STOP  = KHZ * 40000 / 1000;
  localparam int NCOL  = 80;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_read = 1'b0, start_punch = 1'b0, col_read = 1'b0;
  logic buf_we = 1'b0;
  logic [6:0] buf_addr = '0;
  logic [11:0] buf_wdata = '0;
  logic busy, col_irq, complete, overrun;
  logic [6:0] col_num;
  logic [11:0] col_data;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [11:0] mem_m [NCOL];

  always #2 clk = ~clk;

  card_column_sequencer #(.CLK_KHZ(KHZ)) u0 (
    .clk(clk), .rst(rst), .start_read(start_read), .start_punch(start_punch),
    .col_read(col_read), .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .busy(busy), .col_irq(col_irq), .col_num(col_num), .col_data(col_data),
    .complete(complete), .overrun(overrun));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_col(input int s, input int cc);
    if (s < FEED) return 0;
    if (s < FEED + NCOL * cc) return (s - FEED) / cc + 1;
    return NCOL;
  endfunction

  task automatic load_card();
    for (int i = 0; i < NCOL; i++) begin
      @(negedge clk);
      mem_m[i]  = 12'($urandom);
      buf_we    = 1'b1;
      buf_addr  = 7'(i);
      buf_wdata = mem_m[i];
    end
    @(negedge clk);
    buf_we   = 1'b1;
    buf_addr = 7'(NCOL + ($urandom % 48));
    buf_wdata = 12'($urandom);
    @(negedge clk);
    buf_we = 1'b0;
  endtask

  task automatic run_card(input bit punch, input bit both, input int rd_pct, input bit inject);
    int cc = (punch && !both) ? PNC : RDC;
    int last = FEED + NCOL * cc + STOP;
    int inj_s = FEED + ($urandom % (NCOL * cc));
    bit prev_irq = 0, prev_rd = 0, e_ovr = 0;
    int prev_c = 0;
    string ctag = both ? "R11" : (punch ? "R4" : "R3");
    load_card();
    @(negedge clk);
    start_read  = !punch || both;
    start_punch = punch || both;
    for (int s = 0; s <= last + 1; s++) begin
      int c;
      bit in_cols, e_irq;
      @(negedge clk);
      start_read = 1'b0;
      start_punch = 1'b0;
      c = exp_col(s, cc);
      in_cols = (s >= FEED) && (s < FEED + NCOL * cc);
      if (!in_cols) e_irq = 0;
      else if (c != prev_c) e_irq = 1;
      else e_irq = prev_irq && !prev_rd;
      if (in_cols && c != prev_c && prev_c >= 1 && prev_irq && !prev_rd) e_ovr = 1;
      if (s == 0) chk(overrun == 1'b0, "R8", int'(overrun), 0);
      if (s < FEED) chk(busy == 1'b1, "R2", int'(busy), 1);
      else chk(busy == (s < last), "R9", int'(busy), int'(s < last));
      chk(complete == (s == last), "R9", int'(complete), int'(s == last));
      if (in_cols && c != prev_c) chk(col_irq == 1'b1, "R7", int'(col_irq), 1);
      else chk(col_irq == e_irq, "R6", int'(col_irq), int'(e_irq));
      chk(overrun == e_ovr, "R8", int'(overrun), int'(e_ovr));
      if (in_cols) begin
        if (inject && s > inj_s) chk(int'(col_num) == c, "R10", int'(col_num), c);
        else chk(int'(col_num) == c, ctag, int'(col_num), c);
        chk(col_data == mem_m[c-1], "R5", int'(col_data), int'(mem_m[c-1]));
      end else if (s == FEED - 1) begin
        chk(col_num == 7'd0, "R2", int'(col_num), 0);
      end
      col_read = in_cols && (($urandom % 100) < rd_pct);
      if (inject && s == inj_s) begin
        start_read  = punch;
        start_punch = !punch;
      end
      prev_irq = e_irq;
      prev_rd  = col_read;
      prev_c   = in_cols ? c : 0;
    end
    col_read = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(busy == 1'b0 && complete == 1'b0, "R9", int'(busy) + int'(complete), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++;
      total++;
      $display("FAIL watchdog act=%0d exp=%0d", 200000, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(busy == 1'b0, "R1", int'(busy), 0);
    chk(col_irq == 1'b0, "R1", int'(col_irq), 0);
    chk(complete == 1'b0, "R1", int'(complete), 0);
    chk(overrun == 1'b0, "R1", int'(overrun), 0);
    chk(col_num == 7'd0, "R1", int'(col_num), 0);
    run_card(1'b0, 1'b0, 100, 1'b0);
    chk(overrun == 1'b0, "R8", int'(overrun), 0);
    run_card(1'b0, 1'b0, 0, 1'b0);
    chk(overrun == 1'b1, "R8", int'(overrun), 1);
    run_card(1'b0, 1'b0, 30, 1'b1);
    run_card(1'b0, 1'b1, 20, 1'b0);
    run_card(1'b1, 1'b0, 5, 1'b1);
    run_card(1'b1, 1'b0, 60, 1'b0);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule